// File: doc/BRIEF.md
# Row-Latched Flash Array Model

This block is a synthesizable behavioural model of a flash memory split into rows of words. In front of the array sits a one-row staging latch. A load command writes one word into the latch at a chosen offset. Loads can be repeated until the latch holds the row image. A row-write command then programs the whole latch into the addressed row in one operation. Row-erase and bulk-erase commands return cells to the erased state. A programmed bit reads as 0 and an erased bit reads as 1. Programming can only clear bits, so a row must be erased before it can take arbitrary data.

Each write or erase holds a busy flag high for a parameterised number of cycles. Bulk erase lasts longer than row erase, and its length grows with the number of rows. A row write can instead be ended by an external stop strobe. A command that arrives while busy is dropped and answered with a one-cycle error pulse. Stored words are read through a valid/ready request channel. The response channel has no back-pressure: the consumer must take the response in the cycle it appears. Requests are held off (ready low) for the whole time busy is high.

Top module: `rowflash_top`

## Requirements
- R1: After reset, busy, cmd_err and rd_rsp_valid are low, rd_req_ready is high, and every word of the array and of the latch holds all ones.
- R2: A row write stores, in each word of the addressed row, the bitwise AND of the old word and the latch word at the same offset. A write never turns a 0 bit into a 1.
- R3: A load command (cmd_op = 1) accepted while idle places cmd_data into the latch at offset cmd_off. Several loads fill separate offsets. An offset that was not loaded holds all ones and leaves the stored word unchanged on a write.
- R4: A row erase (cmd_op = 3) sets every word of row cmd_row to all ones and leaves every other row unchanged.
- R5: A bulk erase (cmd_op = 4) sets every word of every row to all ones.
- R6: With cmd_ext low, busy rises after the accepting clock edge. It stays high for WRITE_CYC cycles for a row write (cmd_op = 2), ERASE_CYC cycles for a row erase, and BULK_PER_ROW*ROWS cycles for a bulk erase. A load never raises busy.
- R7: A row write issued with cmd_ext high keeps busy high until a cycle in which wr_stop is sampled high. Busy falls at that edge, whatever the cycle count.
- R8: A command offered while busy has no effect on the array or the latch, and cmd_err is high for exactly the one cycle after it.
- R9: rd_req_ready equals not-busy. A request taken at an edge yields rd_rsp_valid high for one cycle after that edge, with the word at rd_addr = {row, offset} as it stood before any command taken at the same edge.
- R10: When a row write is accepted, the latch returns to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 load, 2 row write, 3 row erase, 4 bulk erase |
| cmd_row | input | clog2(ROWS) | Target row for write and row erase |
| cmd_off | input | clog2(ROW_WORDS) | Latch offset for load |
| cmd_data | input | WORD_W | Word for load |
| cmd_ext | input | 1 | Row write ends on wr_stop instead of a count |
| wr_stop | input | 1 | Ends an externally timed write |
| busy | output | 1 | Write or erase in progress |
| cmd_err | output | 1 | One-cycle pulse: command dropped while busy |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready |
| rd_addr | input | clog2(ROWS)+clog2(ROW_WORDS) | Read address {row, offset} |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_data | output | WORD_W | Read response word |

## Verification
The hardest case to reach from the ports is a command that must leave no trace. It is offered in the busy window of another operation. The stimulus starts a row erase and offers a zero-valued load in the very next cycle. After busy falls, it writes a fresh row and reads back the offset that load aimed at. All ones there shows the latch was never touched. A second hard case is the AND rule on a row that already holds data. The table programs a row, programs it again with overlapping patterns, and reads it back without an erase in between.

// File: rtl/rowflash_pkg.sv
package rowflash_pkg;
  typedef enum logic [2:0] {
    OP_LOAD      = 3'd1,
    OP_WRITE     = 3'd2,
    OP_ERASE_ROW = 3'd3,
    OP_ERASE_ALL = 3'd4
  } rf_op_e;
endpackage

// File: rtl/rowflash_latch.sv
module rowflash_latch #(
  parameter int WORD_W    = 16,
  parameter int ROW_WORDS = 4,
  localparam int OFF_AW   = $clog2(ROW_WORDS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [OFF_AW-1:0]                off,
  input  logic [WORD_W-1:0]                data,
  input  logic                             clear,
  output logic [ROW_WORDS-1:0][WORD_W-1:0] words
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      words <= '1;
    end else if (load) begin
      words[off] <= data;
    end
  end

  // R10: the latch is all ones after a committed write
  a_r10_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (&words));
endmodule

// File: rtl/rowflash_timer.sv
module rowflash_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic          ext,
  input  logic          stop,
  output logic          busy
);
  logic [CW-1:0] cnt;
  logic          ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ext_q <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      ext_q <= ext;
      cnt   <= len - CW'(1);
    end else if (busy) begin
      if (ext_q) begin
        if (stop) busy <= 1'b0;
      end else if (cnt == '0) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R7: an externally timed write holds until stop
  a_r7_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext_q && !stop && !start) |=> busy);
  // R6: a counted operation ends only when the count is spent
  a_r6_count_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(ext_q) || $past(cnt) == '0));
endmodule

// File: rtl/rowflash_array.sv
module rowflash_array #(
  parameter int WORD_W    = 16,
  parameter int ROW_WORDS = 4,
  parameter int ROWS      = 8,
  localparam int OFF_AW   = $clog2(ROW_WORDS),
  localparam int ROW_AW   = $clog2(ROWS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             er_row_en,
  input  logic                             er_all_en,
  input  logic [ROW_AW-1:0]                row,
  input  logic [ROW_WORDS-1:0][WORD_W-1:0] latch,
  input  logic                             rd_en,
  input  logic [ROW_AW+OFF_AW-1:0]         rd_addr,
  output logic [WORD_W-1:0]                rd_data
);
  logic [WORD_W-1:0] mem [ROWS][ROW_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n || er_all_en) begin
      for (int r = 0; r < ROWS; r++)
        for (int w = 0; w < ROW_WORDS; w++)
          mem[r][w] <= '1;
    end else if (er_row_en) begin
      for (int w = 0; w < ROW_WORDS; w++)
        mem[row][w] <= '1;
    end else if (wr_en) begin
      for (int w = 0; w < ROW_WORDS; w++)
        mem[row][w] <= mem[row][w] & latch[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr[ROW_AW+OFF_AW-1:OFF_AW]][rd_addr[OFF_AW-1:0]];
  end

  // snapshot for the write-only-clears check
  logic              chk_vld;
  logic [ROW_AW-1:0] chk_row;
  logic [WORD_W-1:0] chk_old;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_vld <= 1'b0;
      chk_row <= '0;
      chk_old <= '0;
    end else begin
      chk_vld <= wr_en && !er_row_en && !er_all_en;
      chk_row <= row;
      chk_old <= mem[row][0];
    end
  end

  // R2: programming never raises a bit
  a_r2_no_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> ((mem[chk_row][0] & ~chk_old) == '0));
  // R4: the erased row reads all ones
  a_r4_row_ones: assert property (@(posedge clk) disable iff (!rst_n)
    er_row_en |=> (&mem[$past(row)][0]));
  // R5: bulk erase reaches the first and last word
  a_r5_bulk_ones: assert property (@(posedge clk) disable iff (!rst_n)
    er_all_en |=> ((&mem[0][0]) && (&mem[ROWS-1][ROW_WORDS-1])));
endmodule

// File: rtl/rowflash_top.sv
module rowflash_top #(
  parameter int WORD_W       = 16,
  parameter int ROW_WORDS    = 4,
  parameter int ROWS         = 8,
  parameter int WRITE_CYC    = 5,
  parameter int ERASE_CYC    = 7,
  parameter int BULK_PER_ROW = 3
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           cmd_valid,
  input  logic [2:0]                                     cmd_op,
  input  logic [$clog2(ROWS)-1:0]                        cmd_row,
  input  logic [$clog2(ROW_WORDS)-1:0]                   cmd_off,
  input  logic [WORD_W-1:0]                              cmd_data,
  input  logic                                           cmd_ext,
  input  logic                                           wr_stop,
  output logic                                           busy,
  output logic                                           cmd_err,
  input  logic                                           rd_req_valid,
  output logic                                           rd_req_ready,
  input  logic [$clog2(ROWS)+$clog2(ROW_WORDS)-1:0]      rd_addr,
  output logic                                           rd_rsp_valid,
  output logic [WORD_W-1:0]                              rd_rsp_data
);
  import rowflash_pkg::*;

  localparam int BULK_CYC = BULK_PER_ROW * ROWS;
  localparam int MAX_CYC  = (BULK_CYC > WRITE_CYC ? (BULK_CYC > ERASE_CYC ? BULK_CYC : ERASE_CYC)
                                                  : (WRITE_CYC > ERASE_CYC ? WRITE_CYC : ERASE_CYC));
  localparam int CW       = $clog2(MAX_CYC + 1) + 1;

  logic accept, do_load, do_write, do_erow, do_eall, do_timed, rd_take;
  logic [CW-1:0] op_len;
  logic [ROW_WORDS-1:0][WORD_W-1:0] latch_words;

  assign accept   = cmd_valid && !busy;
  assign do_load  = accept && (cmd_op == OP_LOAD);
  assign do_write = accept && (cmd_op == OP_WRITE);
  assign do_erow  = accept && (cmd_op == OP_ERASE_ROW);
  assign do_eall  = accept && (cmd_op == OP_ERASE_ALL);
  assign do_timed = do_write || do_erow || do_eall;

  always_comb begin
    if (do_write)     op_len = CW'(WRITE_CYC);
    else if (do_erow) op_len = CW'(ERASE_CYC);
    else              op_len = CW'(BULK_CYC);
  end

  assign rd_req_ready = !busy;
  assign rd_take      = rd_req_valid && rd_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_err      <= 1'b0;
      rd_rsp_valid <= 1'b0;
    end else begin
      cmd_err      <= cmd_valid && busy;
      rd_rsp_valid <= rd_take;
    end
  end

  rowflash_latch #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(do_load), .off(cmd_off),
    .data(cmd_data), .clear(do_write), .words(latch_words));

  rowflash_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(do_timed), .len(op_len),
    .ext(do_write && cmd_ext), .stop(wr_stop), .busy(busy));

  rowflash_array #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .ROWS(ROWS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(do_write), .er_row_en(do_erow),
    .er_all_en(do_eall), .row(cmd_row), .latch(latch_words),
    .rd_en(rd_take), .rd_addr(rd_addr), .rd_data(rd_rsp_data));

  // R8: an error pulse only follows a command that met busy
  a_r8_err_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && busy));
  // R6: busy only starts from an offered command
  a_r6_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  // R9: no response follows a busy cycle
  a_r9_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> $past(!busy));
  // R9: a response lasts one cycle without a new request
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_req_valid) |=> !rd_rsp_valid);
endmodule

// File: tb/rowflash_top_tb.sv
module rowflash_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_row = '0;
  logic [1:0]  cmd_off = '0;
  logic [15:0] cmd_data = '0;
  logic        cmd_ext = 1'b0;
  logic        wr_stop = 1'b0;
  logic        busy, cmd_err, rd_req_ready, rd_rsp_valid;
  logic        rd_req_valid = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rowflash_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_off(cmd_off), .cmd_data(cmd_data), .cmd_ext(cmd_ext),
    .wr_stop(wr_stop), .busy(busy), .cmd_err(cmd_err), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data));

  // table op codes: 0 load, 1 write, 2 row erase, 3 bulk erase, 4 read
  // fields: op[39:37] row[36:34] off[33:32] data[31:16] expected[15:0]
  localparam int NV = 19;
  localparam logic [39:0] VEC [NV] = '{
    {3'd0, 3'd0, 2'd0, 16'hA5A5, 16'h0000},
    {3'd0, 3'd0, 2'd2, 16'h0F0F, 16'h0000},
    {3'd1, 3'd1, 2'd0, 16'h0000, 16'h0000},
    {3'd4, 3'd1, 2'd0, 16'h0000, 16'hA5A5},  // R2 R3
    {3'd4, 3'd1, 2'd1, 16'h0000, 16'hFFFF},  // R3 unloaded offset
    {3'd4, 3'd1, 2'd2, 16'h0000, 16'h0F0F},  // R3
    {3'd0, 3'd0, 2'd0, 16'hFF00, 16'h0000},
    {3'd1, 3'd1, 2'd0, 16'h0000, 16'h0000},
    {3'd4, 3'd1, 2'd0, 16'h0000, 16'hA500},  // R2 AND with old
    {3'd4, 3'd1, 2'd2, 16'h0000, 16'h0F0F},  // R10 latch was reset
    {3'd0, 3'd0, 2'd1, 16'h1234, 16'h0000},
    {3'd1, 3'd2, 2'd0, 16'h0000, 16'h0000},
    {3'd4, 3'd2, 2'd1, 16'h0000, 16'h1234},  // R2
    {3'd2, 3'd1, 2'd0, 16'h0000, 16'h0000},
    {3'd4, 3'd1, 2'd0, 16'h0000, 16'hFFFF},  // R4 erased row
    {3'd4, 3'd2, 2'd1, 16'h0000, 16'h1234},  // R4 other row kept
    {3'd3, 3'd0, 2'd0, 16'h0000, 16'h0000},
    {3'd4, 3'd2, 2'd1, 16'h0000, 16'hFFFF},  // R5
    {3'd4, 3'd7, 2'd3, 16'h0000, 16'hFFFF}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] row, input logic [1:0] off,
                       input logic [15:0] data, input logic ext);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = row; cmd_off = off;
    cmd_data = data; cmd_ext = ext;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_ext = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input logic [2:0] row, input logic [1:0] off,
                          input logic [15:0] exp, input string req);
    rd_req_valid = 1'b1; rd_addr = {row, off};
    @(negedge clk);
    rd_req_valid = 1'b0;
    check(rd_rsp_valid == 1'b1, {req, " rsp_valid"}, rd_rsp_valid, 1);
    check(rd_rsp_data == exp, req, rd_rsp_data, exp);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(cmd_err == 0, "R1 cmd_err", cmd_err, 0);
    check(rd_rsp_valid == 0, "R1 rsp_valid", rd_rsp_valid, 0);
    check(rd_req_ready == 1, "R1 rd_req_ready", rd_req_ready, 1);
    read_chk(3'd5, 2'd2, 16'hFFFF, "R1 array ones");

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][39:37];
      if (op == 3'd4) read_chk(VEC[i][36:34], VEC[i][33:32], VEC[i][15:0], "R2-R5 table read");
      else begin
        issue(op + 3'd1, VEC[i][36:34], VEC[i][33:32], VEC[i][31:16], 1'b0);
        busy_len(n);
      end
    end

    // R6 durations; R3 load does not raise busy
    issue(3'd1, 3'd0, 2'd0, 16'h0000, 1'b0);
    check(busy == 0, "R6 load no busy", busy, 0);
    issue(3'd2, 3'd3, 2'd0, 16'h0000, 1'b0);
    check(rd_req_ready == 0, "R9 ready low while busy", rd_req_ready, 0);
    busy_len(n);
    check(n == 5, "R6 write length", n, 5);
    read_chk(3'd3, 2'd0, 16'h0000, "R3 loaded zero word");
    issue(3'd3, 3'd3, 2'd0, 16'h0000, 1'b0);
    busy_len(n);
    check(n == 7, "R6 row erase length", n, 7);
    issue(3'd4, 3'd0, 2'd0, 16'h0000, 1'b0);
    busy_len(n);
    check(n == 24, "R6 bulk erase length", n, 24);

    // R8 command while busy is dropped
    issue(3'd3, 3'd4, 2'd0, 16'h0000, 1'b0);
    issue(3'd1, 3'd0, 2'd3, 16'h0000, 1'b0);
    check(cmd_err == 1, "R8 err pulse", cmd_err, 1);
    @(negedge clk);
    check(cmd_err == 0, "R8 err one cycle", cmd_err, 0);
    busy_len(n);
    issue(3'd2, 3'd4, 2'd0, 16'h0000, 1'b0);
    busy_len(n);
    read_chk(3'd4, 2'd3, 16'hFFFF, "R8 dropped load left latch");

    // R7 externally ended write
    issue(3'd1, 3'd0, 2'd0, 16'h00FF, 1'b0);
    issue(3'd2, 3'd5, 2'd0, 16'h0000, 1'b1);
    repeat (20) @(negedge clk);
    check(busy == 1, "R7 busy held past count", busy, 1);
    wr_stop = 1'b1;
    @(negedge clk);
    wr_stop = 1'b0;
    check(busy == 0, "R7 busy ends on stop", busy, 0);
    read_chk(3'd5, 2'd0, 16'h00FF, "R7 ext write data");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule